// File: doc/BRIEF.md
# Divide-by-Three System Clock Generator with Ready and Reset Synchronizers

This block takes a fast oscillator clock and turns it into a processor system clock at one third of the oscillator rate. It also makes a peripheral clock at half the system clock rate. For example, a 15 MHz oscillator gives a 5 MHz system clock and a 2.5 MHz peripheral clock. The system clock is high for one oscillator period and low for two.

The block also brings two asynchronous requests into the system clock timing:
- A reset request. The synchronized reset is released only on a falling edge of the system clock.
- A ready request. The synchronized ready only moves on a rising edge of the system clock.

All logic runs on the oscillator clock. Each system clock edge appears as a one-cycle enable inside that domain, so there is no second clock tree. The reset request also holds the divider at its start point. The outputs therefore start from a known phase when the request goes away.

Top module: `clkgen_top`

## Requirements
- R1: While `rst_req` is high, and asynchronously from the moment it rises: `sys_clk` = 0, `per_clk` = 0, `rst_sync` = 1, `rdy_sync` = 0. The divider is held at count zero.
- R2: `sys_clk` has a period of three oscillator cycles: high for one, low for two. After `rst_req` falls, its first rising edge is on the third `osc_clk` rising edge.
- R3: `per_clk` toggles on every falling edge of `sys_clk` and at no other time. This gives a 50% duty cycle and a period of six oscillator cycles.
- R4: After `rst_req` falls, `rst_sync` stays high until the second falling edge of `sys_clk`. It goes low exactly on that edge, which is the seventh `osc_clk` rising edge.
- R5: `rdy_sync` changes only on a rising edge of `sys_clk`. It takes a new `rdy_req` level on the second `sys_clk` rising edge at which that level is present.
- R6: A `rdy_req` pulse that ends before the next `sys_clk` rising edge has no effect on `rdy_sync`.
- R7: Re-asserting `rst_req` during operation forces the R1 output state at once, without waiting for an oscillator edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock, three times the system clock rate |
| rst_req | input | 1 | Asynchronous reset request, active high |
| rdy_req | input | 1 | Asynchronous ready request, active high |
| sys_clk | output | 1 | System clock, one third duty cycle |
| per_clk | output | 1 | Peripheral clock, half the system clock rate |
| rst_sync | output | 1 | Reset, released on a system clock falling edge |
| rdy_sync | output | 1 | Ready, updated on system clock rising edges |

## Verification
The hardest situation to reach from the ports is a short ready pulse that falls entirely between two system clock rising edges. The bench waits until it sees `sys_clk` high, which marks the oscillator cycle just after a rising edge. It then flips `rdy_req` for exactly one oscillator cycle, so the pulse covers only an edge where no capture happens. It also starts ready changes at several different phases of the divider. This shows that the two-rising-edge latency does not depend on where the change lands within the three-cycle period.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

   // Per-cycle markers for the system clock edges, in the oscillator domain
   typedef struct packed {
      logic rise;   // sys_clk goes high on this oscillator edge
      logic fall;   // sys_clk goes low on this oscillator edge
   } sys_edge_t;

   function automatic int cnt_width(input int ratio);
      return (ratio <= 2) ? 1 : $clog2(ratio);
   endfunction

endpackage

// File: rtl/clkgen_div.sv
module clkgen_div
   import clkgen_pkg::*;
#(
   parameter int RATIO = 3,
   parameter int HIGH  = 1
) (
   input  logic      osc_clk,
   input  logic      rst_req,
   output logic      sys_clk,
   output sys_edge_t edges
);
   localparam int CW = cnt_width(RATIO);
   localparam logic [CW-1:0] LAST   = CW'(RATIO - 1);
   localparam logic [CW-1:0] HI_END = CW'(HIGH - 1);
   localparam logic [CW-1:0] HI_LIM = CW'(HIGH);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;
   logic          sys_q;

   always_comb begin
      if (cnt_q == LAST) cnt_nx = '0;
      else               cnt_nx = cnt_q + CW'(1);
   end

   always_ff @(posedge osc_clk or posedge rst_req) begin
      if (rst_req) begin
         cnt_q <= '0;
         sys_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nx;
         sys_q <= (cnt_nx < HI_LIM);
      end
   end

   always_comb begin
      edges.rise = (cnt_q == LAST);
      edges.fall = sys_q && (cnt_q == HI_END);
   end

   assign sys_clk = sys_q;

endmodule

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst,
   input  logic en,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stg;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic din;
      if (i == 0) begin : g_head
         assign din = d;
      end else begin : g_link
         assign din = stg[i-1];
      end
      always_ff @(posedge clk or posedge arst) begin
         if (arst)    stg[i] <= RST_VAL;
         else if (en) stg[i] <= din;
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
   import clkgen_pkg::*;
#(
   parameter int DIV_RATIO   = 3,
   parameter int HIGH_CYCLES = 1,
   parameter int RST_STAGES  = 2,
   parameter int RDY_STAGES  = 2
) (
   input  logic osc_clk,
   input  logic rst_req,
   input  logic rdy_req,
   output logic sys_clk,
   output logic per_clk,
   output logic rst_sync,
   output logic rdy_sync
);
   if (DIV_RATIO < 2) begin : g_bad_ratio
      $error("DIV_RATIO must be at least 2");
   end
   if (HIGH_CYCLES < 1 || HIGH_CYCLES >= DIV_RATIO) begin : g_bad_high
      $error("HIGH_CYCLES must lie in 1..DIV_RATIO-1");
   end
   if (RST_STAGES < 2 || RDY_STAGES < 2) begin : g_bad_stages
      $error("synchronizers need at least two stages");
   end

   sys_edge_t edges;
   logic      per_q;

   clkgen_div #(
      .RATIO (DIV_RATIO),
      .HIGH  (HIGH_CYCLES)
   ) u_div (
      .osc_clk (osc_clk),
      .rst_req (rst_req),
      .sys_clk (sys_clk),
      .edges   (edges)
   );

   // peripheral clock: toggle at each system clock falling edge
   always_ff @(posedge osc_clk or posedge rst_req) begin
      if (rst_req)         per_q <= 1'b0;
      else if (edges.fall) per_q <= ~per_q;
   end
   assign per_clk = per_q;

   // reset release aligned to system clock falling edges
   clkgen_sync #(
      .STAGES  (RST_STAGES),
      .RST_VAL (1'b1)
   ) u_rst_sync (
      .clk  (osc_clk),
      .arst (rst_req),
      .en   (edges.fall),
      .d    (1'b0),
      .q    (rst_sync)
   );

   // ready sampled on system clock rising edges
   clkgen_sync #(
      .STAGES  (RDY_STAGES),
      .RST_VAL (1'b0)
   ) u_rdy_sync (
      .clk  (osc_clk),
      .arst (rst_req),
      .en   (edges.rise),
      .d    (rdy_req),
      .q    (rdy_sync)
   );

endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk (
   input logic osc_clk,
   input logic rst_req,
   input logic rdy_req,
   input logic sys_clk,
   input logic per_clk,
   input logic rst_sync,
   input logic rdy_sync
);
   AST_RST_WHILE_REQ: assert property (@(posedge osc_clk) rst_req |-> (rst_sync && !sys_clk && !rdy_sync)); // R1
   AST_SYS_HIGH_ONE: assert property (@(posedge osc_clk) disable iff (rst_req) sys_clk |=> !sys_clk); // R2
   AST_SYS_LOW_TWO: assert property (@(posedge osc_clk) disable iff (rst_req) $fell(sys_clk) |=> !sys_clk); // R2
   AST_PER_ON_FALL: assert property (@(posedge osc_clk) disable iff (rst_req) !$stable(per_clk) |-> $fell(sys_clk)); // R3
   AST_RST_ON_FALL: assert property (@(posedge osc_clk) disable iff (rst_req) $fell(rst_sync) |-> $fell(sys_clk)); // R4
   AST_RDY_ON_RISE: assert property (@(posedge osc_clk) disable iff (rst_req) !$stable(rdy_sync) |-> $rose(sys_clk)); // R5
endmodule

bind clkgen_top clkgen_chk u_chk (
   .osc_clk  (osc_clk),
   .rst_req  (rst_req),
   .rdy_req  (rdy_req),
   .sys_clk  (sys_clk),
   .per_clk  (per_clk),
   .rst_sync (rst_sync),
   .rdy_sync (rdy_sync)
);

// File: tb/sim_clkgen_top.sv
`timescale 1ns/1ps
module sim_clkgen_top;
   logic osc_clk = 1'b0;
   logic rst_req;
   logic rdy_req;
   logic sys_clk, per_clk, rst_sync, rdy_sync;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 osc_clk = ~osc_clk;

   clkgen_top u0 (
      .osc_clk  (osc_clk),
      .rst_req  (rst_req),
      .rdy_req  (rdy_req),
      .sys_clk  (sys_clk),
      .per_clk  (per_clk),
      .rst_sync (rst_sync),
      .rdy_sync (rdy_sync)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic t_reset_state();
      check(sys_clk == 1'b0, "R1 sys_clk in reset", int'(sys_clk), 0);
      check(per_clk == 1'b0, "R1 per_clk in reset", int'(per_clk), 0);
      check(rst_sync == 1'b1, "R1 rst_sync in reset", int'(rst_sync), 1);
      check(rdy_sync == 1'b0, "R1 rdy_sync in reset", int'(rdy_sync), 0);
   endtask

   // release reset on a negedge, then check the first 24 oscillator cycles
   task automatic t_release();
      rst_req = 1'b0;
      for (int i = 1; i <= 24; i++) begin
         @(negedge osc_clk);
         check(sys_clk == ((i % 3) == 0), "R2 sys_clk pattern", int'(sys_clk), int'((i % 3) == 0));
         check(per_clk == (((i - 1) / 3) % 2 == 1), "R3 per_clk pattern", int'(per_clk),
               int'(((i - 1) / 3) % 2 == 1));
         check(rst_sync == (i < 7), "R4 rst_sync release", int'(rst_sync), int'(i < 7));
      end
   endtask

   // change ready at the current phase; new level shows at second sys rise
   task automatic t_ready(input logic lvl);
      logic old;
      int   rises;
      old     = rdy_sync;
      rdy_req = lvl;
      rises   = 0;
      for (int i = 0; i < 9; i++) begin
         @(negedge osc_clk);
         if (sys_clk) rises++;
         check(rdy_sync == ((rises >= 2) ? lvl : old), "R5 rdy_sync latency",
               int'(rdy_sync), int'((rises >= 2) ? lvl : old));
      end
   endtask

   // one-cycle pulse placed just after a sys rise, removed before the next
   task automatic t_ready_pulse();
      logic base;
      base = rdy_sync;
      do @(negedge osc_clk); while (!sys_clk);
      rdy_req = ~base;
      @(negedge osc_clk);
      rdy_req = base;
      for (int i = 0; i < 9; i++) begin
         @(negedge osc_clk);
         check(rdy_sync == base, "R6 short ready pulse ignored", int'(rdy_sync), int'(base));
      end
   endtask

   task automatic t_async_reset();
      do @(negedge osc_clk); while (!sys_clk);
      check(rdy_sync == 1'b1, "R7 ready high before reset", int'(rdy_sync), 1);
      #1 rst_req = 1'b1;
      #1;
      check(sys_clk == 1'b0, "R7 sys_clk drops at once", int'(sys_clk), 0);
      check(rst_sync == 1'b1, "R7 rst_sync rises at once", int'(rst_sync), 1);
      check(rdy_sync == 1'b0, "R7 rdy_sync clears at once", int'(rdy_sync), 0);
      for (int i = 0; i < 4; i++) begin
         @(negedge osc_clk);
         t_reset_state();
      end
   endtask

   initial begin
      rst_req = 1'b1;
      rdy_req = 1'b0;
      repeat (3) @(negedge osc_clk);
      t_reset_state();
      t_release();
      t_ready(1'b1);
      @(negedge osc_clk);
      t_ready(1'b0);
      repeat (2) @(negedge osc_clk);
      t_ready(1'b1);
      t_ready_pulse();
      rdy_req = 1'b1;
      t_async_reset();
      rdy_req = 1'b0;
      t_release();
      t_ready_pulse();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge osc_clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         end
      join_any
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule